// File: doc/BRIEF.md
# Reloading Interval Counter with Capture and Compare

This block is a byte-programmed timer built around a 12-bit up-counter. The counter advances by one on each pulse from a selected count-enable source. It offers three sources and an "off" setting. When the counter steps past its all-ones value it does not return to zero. It restarts from a software-loaded reload value, so one overflow period is set by that value. A capture input takes a snapshot of the counter. A compare register raises a flag when the counter reaches a chosen value.

Software reaches the block through a small register port made of an address, a write strobe, a read strobe and byte-wide data in both directions. Reading some registers has side effects: the status flags are cleared by reads, not by writes. A change of count source is held back until the next overflow, so the current period always finishes on the old source. All count sources arrive as one-cycle enable pulses in the block's own clock, which keeps the design in a single clock domain. The block has no streaming data path, so every pin is a plain control or status signal and no valid/ready handshake applies.

Top module: `arl_timer`

## Requirements
- R1: After reset the control/status register (address 0) reads 0x00, the counter reads 0, `irq` is low, and no source pulse moves the counter.
- R2: Control/status bits 4:3 pick the count source: 00 = off, 01 = `src_tick[0]`, 10 = `src_tick[1]`, 11 = `src_tick[2]`. Each pulse of the active source raises the counter by one. Pulses on sources that are not active, and cycles with no pulse, leave the counter unchanged.
- R3: A pulse taken while the counter holds 0xFFF loads the counter with the reload value instead of zero. It also sets the overflow flag (control/status bit 2).
- R4: A read of address 0 returns the flags as they were before the read and clears the overflow flag and the compare flag (bit 7).
- R5: A written source selection shows at once in bits 4:3 of the register. While a source is running, the counter keeps counting on the old source until the next overflow. While the source is off, the new one takes over in the next cycle.
- R6: A read of address 1 returns counter bits 7:0 and latches counter bits 11:8. The next read of address 2 returns the latched bits in bits 3:0 and zeros in bits 7:4, even if the counter has moved in between.
- R7: A `cap_evt` pulse copies the counter value held before that cycle's step into the capture register. Its low byte is at address 5 and its bits 11:8 are at address 6, bits 3:0. The pulse also sets the capture flag (control/status bit 6).
- R8: A read of address 5 or 6 clears the capture flag. A write to address 0 leaves bits 7, 6 and 2 unchanged.
- R9: The compare flag is set when a count step brings the counter to the compare value. The compare value's low byte is at address 7 and its bits 11:8 are at address 8, bits 3:0.
- R10: `irq` = (bit2 AND bit1) OR (bit6 AND bit5) OR (bit7 AND bit0) of the control/status register. Clearing bit 0 masks the compare request without altering the compare flag.
- R11: The reload value is written and read back at address 3 (bits 7:0) and address 4 (bits 11:8 in bits 3:0). On reads, the upper four bits of addresses 4 and 8 are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_tick | input | 3 | One-cycle count-enable pulses, one per source |
| cap_evt | input | 1 | One-cycle capture request |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe, data taken at the clock edge |
| bus_rd | input | 1 | Read strobe, side effects at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after the read strobe |
| irq | output | 1 | Combined, masked interrupt request |

## Verification
The risky states here are the active source selection, which software cannot read directly, and the three flags. A source selection that changes too early shows up as the counter moving on a pulse from the newly requested source before the overflow; the next low-byte read exposes it. A stale or lost flag shows on `irq` in the cycle after the event, and in the first control/status read after it. A wrong reload value appears in the counter read that follows the overflow. A broken high-byte shadow appears only when the counter crosses a byte boundary between the two counter reads, so the bench places the low-byte read just before such a carry.

// File: rtl/arl_pkg.sv
package arl_pkg;
  typedef enum logic [3:0] {
    A_CSR  = 4'd0,
    A_CNTL = 4'd1,
    A_CNTH = 4'd2,
    A_RLDL = 4'd3,
    A_RLDH = 4'd4,
    A_CAPL = 4'd5,
    A_CAPH = 4'd6,
    A_CMPL = 4'd7,
    A_CMPH = 4'd8
  } reg_addr_e;

  localparam int B_CMPIE = 0;
  localparam int B_OVFIE = 1;
  localparam int B_OVF   = 2;
  localparam int B_SEL0  = 3;
  localparam int B_SEL1  = 4;
  localparam int B_ICIE  = 5;
  localparam int B_ICF   = 6;
  localparam int B_CMPF  = 7;
endpackage

// File: rtl/arl_src_sel.sv
module arl_src_sel #(
  parameter int N_SRC = 3,
  parameter int SEL_W = 2
) (
  input  logic [N_SRC-1:0] src_tick,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int N_ENT = 1 << SEL_W;

  logic [N_ENT-1:0] en_vec;

  // Entry 0 is the "off" setting; unused codes above N_SRC never count.
  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    if (g == 0 || g > N_SRC) begin : g_zero
      assign en_vec[g] = 1'b0;
    end else begin : g_src
      assign en_vec[g] = src_tick[g-1];
    end
  end

  assign tick = en_vec[sel];
endmodule

// File: rtl/arl_counter.sv
module arl_counter #(
  parameter int CNT_W = 12,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [SEL_W-1:0] sel_req,
  input  logic [CNT_W-1:0] reload,
  input  logic [CNT_W-1:0] cmp_val,
  output logic [CNT_W-1:0] cnt,
  output logic [SEL_W-1:0] sel_act,
  output logic             ovf_evt,
  output logic             cmp_evt
);
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  logic             at_max;
  logic [CNT_W-1:0] cnt_nxt;

  assign at_max  = (cnt == MAXV);
  assign cnt_nxt = at_max ? reload : cnt + 1'b1;
  assign ovf_evt = tick & at_max;
  assign cmp_evt = tick & (cnt_nxt == cmp_val);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      sel_act <= '0;
    end else begin
      if (tick) cnt <= cnt_nxt;
      // A running source is only swapped at the period boundary.
      if (ovf_evt || sel_act == '0) sel_act <= sel_req;
    end
  end
endmodule

// File: rtl/arl_capture.sv
module arl_capture #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_evt,
  input  logic             clr,
  input  logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cap_val,
  output logic             icf
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_val <= '0;
      icf     <= 1'b0;
    end else begin
      if (cap_evt) cap_val <= cnt;
      // A new capture wins over a clearing read in the same cycle.
      icf <= cap_evt | (icf & ~clr);
    end
  end
endmodule

// File: rtl/arl_timer.sv
module arl_timer #(
  parameter int CNT_W = 12,
  parameter int N_SRC = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_tick,
  input  logic             cap_evt,
  input  logic [3:0]       bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  output logic             irq
);
  import arl_pkg::*;

  localparam int SEL_W = $clog2(N_SRC + 1);

  logic             icie, ovfie, cmpie;
  logic [SEL_W-1:0] sel_req, sel_act;
  logic             ovf_flag, cmpf;
  logic [CNT_W-1:0] reload, cmp_val, cnt, cap_val;
  logic [7:0]       cnt_hi_sh;
  logic             tick, ovf_evt, cmp_evt, icf;
  logic             rd_csr, cap_clr, csr_wr;
  logic [15:0]      cnt_x, rld_x, cap_x, cmp_x;
  logic [7:0]       csr_view, rd_val;

  arl_src_sel #(.N_SRC(N_SRC), .SEL_W(SEL_W)) u_sel (
    .src_tick (src_tick),
    .sel      (sel_act),
    .tick     (tick)
  );

  arl_counter #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .sel_req (sel_req),
    .reload  (reload),
    .cmp_val (cmp_val),
    .cnt     (cnt),
    .sel_act (sel_act),
    .ovf_evt (ovf_evt),
    .cmp_evt (cmp_evt)
  );

  arl_capture #(.CNT_W(CNT_W)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap_evt (cap_evt),
    .clr     (cap_clr),
    .cnt     (cnt),
    .cap_val (cap_val),
    .icf     (icf)
  );

  assign cnt_x = 16'(cnt);
  assign rld_x = 16'(reload);
  assign cap_x = 16'(cap_val);
  assign cmp_x = 16'(cmp_val);

  assign rd_csr  = bus_rd && (bus_addr == A_CSR);
  assign cap_clr = bus_rd && (bus_addr == A_CAPL || bus_addr == A_CAPH);
  assign csr_wr  = bus_wr && (bus_addr == A_CSR);

  always_comb begin
    csr_view          = '0;
    csr_view[B_CMPF]  = cmpf;
    csr_view[B_ICF]   = icf;
    csr_view[B_ICIE]  = icie;
    csr_view[B_SEL1]  = sel_req[1];
    csr_view[B_SEL0]  = sel_req[0];
    csr_view[B_OVF]   = ovf_flag;
    csr_view[B_OVFIE] = ovfie;
    csr_view[B_CMPIE] = cmpie;
  end

  always_comb begin
    case (bus_addr)
      A_CSR:   rd_val = csr_view;
      A_CNTL:  rd_val = cnt_x[7:0];
      A_CNTH:  rd_val = cnt_hi_sh;
      A_RLDL:  rd_val = rld_x[7:0];
      A_RLDH:  rd_val = rld_x[15:8];
      A_CAPL:  rd_val = cap_x[7:0];
      A_CAPH:  rd_val = cap_x[15:8];
      A_CMPL:  rd_val = cmp_x[7:0];
      A_CMPH:  rd_val = cmp_x[15:8];
      default: rd_val = '0;
    endcase
  end

  // Control bits and the programmable values.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      icie    <= 1'b0;
      ovfie   <= 1'b0;
      cmpie   <= 1'b0;
      sel_req <= '0;
      reload  <= '0;
      cmp_val <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_CSR: begin
          icie    <= bus_wdata[B_ICIE];
          sel_req <= bus_wdata[B_SEL1:B_SEL0];
          ovfie   <= bus_wdata[B_OVFIE];
          cmpie   <= bus_wdata[B_CMPIE];
        end
        A_RLDL: reload  <= CNT_W'({rld_x[15:8], bus_wdata});
        A_RLDH: reload  <= CNT_W'({bus_wdata, rld_x[7:0]});
        A_CMPL: cmp_val <= CNT_W'({cmp_x[15:8], bus_wdata});
        A_CMPH: cmp_val <= CNT_W'({bus_wdata, cmp_x[7:0]});
        default: ;
      endcase
    end
  end

  // Read-cleared flags: a fresh event in the clearing cycle is kept.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_flag <= 1'b0;
      cmpf     <= 1'b0;
    end else begin
      ovf_flag <= ovf_evt | (ovf_flag & ~rd_csr);
      cmpf     <= cmp_evt | (cmpf & ~rd_csr);
    end
  end

  // Read data register and the counter high-byte shadow.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      cnt_hi_sh <= '0;
    end else if (bus_rd) begin
      bus_rdata <= rd_val;
      if (bus_addr == A_CNTL) cnt_hi_sh <= cnt_x[15:8];
    end
  end

  assign irq = (ovf_flag & ovfie) | (icf & icie) | (cmpf & cmpie);
endmodule

// File: rtl/arl_timer_chk.sv
module arl_timer_chk #(
  parameter int CNT_W = 12,
  parameter int SEL_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] reload,
  input logic             ovf_evt,
  input logic             ovf_flag,
  input logic             rd_csr,
  input logic [SEL_W-1:0] sel_act,
  input logic             cap_evt,
  input logic             cap_clr,
  input logic [CNT_W-1:0] cap_val,
  input logic             icf,
  input logic             cmp_evt,
  input logic             cmpf,
  input logic             irq
);
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tick && cnt != MAXV |=> cnt == CNT_W'($past(cnt) + 1'b1)); // R2
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> cnt == $past(cnt)); // R2
  AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> cnt == $past(reload) && ovf_flag); // R3
  AST_OVF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    rd_csr && !ovf_evt |=> !ovf_flag); // R4
  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    sel_act != '0 && !ovf_evt |=> $stable(sel_act)); // R5
  AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> cap_val == $past(cnt) && icf); // R7
  AST_ICF_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_evt && !cap_clr |=> icf == $past(icf)); // R8
  AST_CMPF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_evt |=> cmpf); // R9
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf_flag && !icf && !cmpf |-> !irq); // R10
endmodule

bind arl_timer arl_timer_chk #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (tick),
  .cnt      (cnt),
  .reload   (reload),
  .ovf_evt  (ovf_evt),
  .ovf_flag (ovf_flag),
  .rd_csr   (rd_csr),
  .sel_act  (sel_act),
  .cap_evt  (cap_evt),
  .cap_clr  (cap_clr),
  .cap_val  (cap_val),
  .icf      (icf),
  .cmp_evt  (cmp_evt),
  .cmpf     (cmpf),
  .irq      (irq)
);

// File: tb/arl_timer_tb.sv
`timescale 1ns/1ps
module arl_timer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] src_tick = '0;
  logic       cap_evt = 1'b0;
  logic [3:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  arl_timer u_dut (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .cap_evt(cap_evt),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // {op(1=read-check), addr[3:0], data[7:0], expect[7:0]}
  localparam int NV = 15;
  localparam logic [20:0] VEC [NV] = '{
    {1'b0, 4'd3, 8'hF0, 8'h00},
    {1'b0, 4'd4, 8'hFF, 8'h00},
    {1'b1, 4'd4, 8'h00, 8'h0F},
    {1'b0, 4'd4, 8'h0F, 8'h00},
    {1'b1, 4'd3, 8'h00, 8'hF0},
    {1'b1, 4'd4, 8'h00, 8'h0F},
    {1'b0, 4'd8, 8'hF3, 8'h00},
    {1'b1, 4'd8, 8'h00, 8'h03},
    {1'b0, 4'd8, 8'h00, 8'h00},
    {1'b0, 4'd7, 8'h05, 8'h00},
    {1'b1, 4'd7, 8'h00, 8'h05},
    {1'b1, 4'd8, 8'h00, 8'h00},
    {1'b1, 4'd1, 8'h00, 8'h00},
    {1'b0, 4'd0, 8'h0A, 8'h00},
    {1'b1, 4'd0, 8'h00, 8'h0A}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] a, input logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    check(tag, d, exp);
  endtask

  task automatic run(input int idx, input int n);
    @(negedge clk);
    src_tick[idx] = 1'b1;
    repeat (n) @(negedge clk);
    src_tick = '0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state, source off
    rd_chk("R1 csr", 4'd0, 8'h00);
    rd_chk("R1 cntl", 4'd1, 8'h00);
    check("R1 irq", {7'b0, irq}, 8'h00);
    @(negedge clk); src_tick = 3'b111;
    repeat (5) @(negedge clk); src_tick = '0;
    rd_chk("R1 off no count", 4'd1, 8'h00);

    // R11/R9/R5 register table walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][20]) rd_chk("R11 table", VEC[i][19:16], VEC[i][7:0]);
      else wr(VEC[i][19:16], VEC[i][15:8]);
    end

    // R5: selection applied at once while off; R2 counting on source 0
    run(0, 3);
    run(1, 4);
    rd_chk("R2 count src0", 4'd1, 8'h03);
    rd_chk("R6 cnth", 4'd2, 8'h00);

    // R9/R10: compare at 5, masked
    run(0, 2);
    check("R10 cmp masked irq", {7'b0, irq}, 8'h00);
    rd_chk("R9 cmpf set", 4'd0, 8'h8A);
    rd_chk("R4 cmpf cleared", 4'd0, 8'h0A);

    // R5: request source 10 while source 01 runs
    wr(4'd0, 8'h12);
    rd_chk("R5 sel visible", 4'd0, 8'h12);
    run(1, 3);
    rd_chk("R5 old source kept", 4'd1, 8'h05);

    // R6: coherent high byte across a carry
    run(0, 250);
    rd_chk("R6 cntl before carry", 4'd1, 8'hFF);
    run(0, 1);
    rd_chk("R6 shadow high", 4'd2, 8'h00);
    rd_chk("R6 cntl after", 4'd1, 8'h00);
    rd_chk("R6 cnth after", 4'd2, 8'h01);

    // R3: overflow into reload 0xFF0
    run(0, 3839);
    rd_chk("R3 at max lo", 4'd1, 8'hFF);
    rd_chk("R3 at max hi", 4'd2, 8'h0F);
    check("R10 no irq before ovf", {7'b0, irq}, 8'h00);
    run(0, 1);
    check("R10 ovf irq", {7'b0, irq}, 8'h01);
    rd_chk("R3 ovf flag", 4'd0, 8'h16);
    check("R4 irq after csr read", {7'b0, irq}, 8'h00);
    rd_chk("R4 ovf cleared", 4'd0, 8'h12);
    rd_chk("R3 reload lo", 4'd1, 8'hF0);

    // R5: new source active after overflow
    run(0, 3);
    run(1, 2);
    rd_chk("R5 new source", 4'd1, 8'hF2);

    // R7/R8: capture
    @(negedge clk); cap_evt = 1'b1;
    @(negedge clk); cap_evt = 1'b0;
    rd_chk("R7 icf set", 4'd0, 8'h52);
    wr(4'd0, 8'h32);
    check("R10 icf irq", {7'b0, irq}, 8'h01);
    rd_chk("R8 write keeps icf", 4'd0, 8'h72);
    rd_chk("R7 cap lo", 4'd5, 8'hF2);
    rd_chk("R8 icf cleared", 4'd0, 8'h32);
    check("R8 irq low", {7'b0, irq}, 8'h00);
    rd_chk("R7 cap hi", 4'd6, 8'h0F);
    wr(4'd0, 8'hF6);
    rd_chk("R8 write cannot set flags", 4'd0, 8'h32);

    // R9/R10: compare with enable
    wr(4'd7, 8'hF4);
    wr(4'd8, 8'h0F);
    wr(4'd0, 8'h33);
    run(1, 2);
    check("R10 cmp irq", {7'b0, irq}, 8'h01);
    rd_chk("R9 cmpf", 4'd0, 8'hB3);
    check("R4 cmp irq cleared", {7'b0, irq}, 8'h00);

    // R7: capture in a counting cycle takes the pre-step value
    @(negedge clk); cap_evt = 1'b1; src_tick[1] = 1'b1;
    @(negedge clk); cap_evt = 1'b0; src_tick = '0;
    rd_chk("R7 cap pre-step", 4'd5, 8'hF4);
    rd_chk("R2 counter moved", 4'd1, 8'hF5);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule